// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Line Status

This block turns an asynchronous serial line into received bytes. A 16x oversampling tick, supplied from outside, drives a frame engine. The engine spots a falling edge and confirms the start bit half a bit later. It then samples each data bit, the optional parity bit and the stop bit at their midpoints. Each finished character goes into a one-byte holding buffer. Parity, framing and break conditions go into sticky status flags.

The surrounding register logic reads the block through three strobes:
- A consuming read returns the byte and clears data-available.
- A shadow read returns the same byte and leaves data-available set.
- A status read returns the line status byte and clears the error flags.

Two request lines go to the interrupt logic: one for data-available and one for any error. In loopback mode the receiver takes its input from the local transmitter output rather than the external pin. Both request lines stay low in that mode.

Top module: `serial_rx_status`

## Requirements
- R1: A low level seen on a tick starts a frame only if the line is still low on the 8th tick after that one. A shorter low pulse is dropped, and no character is produced for it.
- R2: Data bits are received LSB first. `word_len` selects the number of data bits: 00 gives 5, 01 gives 6, 10 gives 7, 11 gives 8. Unused upper bits of the received byte read as 0.
- R3: `rd_data` loads the buffered byte onto `rdata` at the next clock edge and clears data-available (`status[0]`). A character completing in the same cycle keeps data-available set.
- R4: `rd_shadow` loads the buffered byte onto `rdata` and leaves `status[0]` unchanged.
- R5: If a character completes while data-available is still set, the new byte replaces the old one and the overrun flag (`status[1]`) is set.
- R6: With `parity_en` high, the parity error flag (`status[2]`) is set when the received parity bit differs from the selected rule. `parity_kind` 00 is odd, 01 is even, 10 expects 1 and 11 expects 0. With `parity_en` low, no parity bit is received and no parity error is flagged.
- R7: A stop bit sampled at 0 sets the framing flag (`status[3]`).
- R8: A character whose data, parity and stop samples are all 0 sets the break flag (`status[4]`) and delivers byte 0. The receiver then waits for the line to return high, so a long break gives exactly one character.
- R9: `rd_status` loads `status` onto `rdata` and clears bits 1 to 4. An error arriving in the same cycle as the read stays set. Bits 7 to 5 are always 0.
- R10: `avail_irq` follows `status[0]`. `err_irq` is high while any of `status[4:1]` is set. Both are held low while `loop_en` is high.
- R11: With `loop_en` high, the receiver samples `loop_txd` and ignores `rxd`.
- R12: After reset, `status`, `rdata`, `avail_irq` and `err_irq` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| baud_tick | input | 1 | One-cycle pulse at 16 times the bit rate |
| rxd | input | 1 | External serial input, idle high |
| loop_en | input | 1 | Loopback select |
| loop_txd | input | 1 | Local transmitter output used in loopback |
| word_len | input | 2 | Data bit count select |
| parity_en | input | 1 | Parity bit present and checked |
| parity_kind | input | 2 | Parity rule select |
| rd_data | input | 1 | Consuming byte read strobe |
| rd_shadow | input | 1 | Non-consuming byte read strobe |
| rd_status | input | 1 | Status read strobe |
| rdata | output | 8 | Read result, valid the cycle after a strobe |
| status | output | 8 | Live line status {000, break, framing, parity, overrun, avail} |
| avail_irq | output | 1 | Data-available request |
| err_irq | output | 1 | Line error request |

## Verification
Clean frames at several word lengths show whether bits arrive in order and whether the upper bits are zero-padded. The patterns 0xA5 and 0x3C tell a correct bit order from a reversed one. Frames with deliberately wrong parity, a zero stop bit, or a line held low for longer than a frame separate the three error flags from one another. Two bytes sent without a read test the overwrite rule, and a short low pulse tests start-bit confirmation. A frame delivered only on the loopback input while the pin is held low shows that the pin is ignored and the requests stay quiet. A status read held active through an erroring stop bit shows that a new error outlasts a same-cycle clear.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [1:0] {
        WLEN5 = 2'b00,
        WLEN6 = 2'b01,
        WLEN7 = 2'b10,
        WLEN8 = 2'b11
    } wlen_e;

    typedef enum logic [1:0] {
        PAR_ODD   = 2'b00,
        PAR_EVEN  = 2'b01,
        PAR_MARK  = 2'b10,
        PAR_SPACE = 2'b11
    } par_kind_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PAR,
        ST_STOP,
        ST_HOLD
    } rx_state_e;

    typedef struct packed {
        wlen_e     wlen;
        logic      par_en;
        par_kind_e par_kind;
    } rx_cfg_t;

    typedef struct packed {
        logic [BYTE_W-1:0] data;
        logic              perr;
        logic              ferr;
        logic              brk;
    } rx_event_t;

    // index of the final data bit for a word length code
    function automatic logic [2:0] last_bit_idx(input wlen_e w);
        return 3'd4 + {1'b0, w};
    endfunction

    // bits of the byte that a word length actually fills
    function automatic logic [BYTE_W-1:0] width_mask(input wlen_e w);
        return 8'hFF >> (2'd3 - w);
    endfunction

    // parity bit value the sender should have produced
    function automatic logic parity_expect(input logic [BYTE_W-1:0] d,
                                           input par_kind_e k);
        case (k)
            PAR_ODD:  return ~(^d);
            PAR_EVEN: return ^d;
            PAR_MARK: return 1'b1;
            default:  return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/rx_line_select.sv
module rx_line_select #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic rxd,
    input  logic loop_en,
    input  logic loop_txd,
    output logic line
);
    logic       raw;
    logic [SYNC_STAGES-1:0] chain;

    assign raw = loop_en ? loop_txd : rxd;

    generate
        for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_sync
            always_ff @(posedge clk) begin
                if (rst)
                    chain[i] <= 1'b1;
                else if (i == 0)
                    chain[i] <= raw;
                else
                    chain[i] <= chain[(i == 0) ? 0 : i-1];
            end
        end
    endgenerate

    assign line = chain[SYNC_STAGES-1];

endmodule

// File: rtl/rx_frame_engine.sv
module rx_frame_engine
    import serial_rx_pkg::*;
#(
    parameter int OVERSAMPLE = 16
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      tick,
    input  logic      line,
    input  rx_cfg_t   cfg,
    output logic      ev_valid,
    output rx_event_t ev
);
    localparam int CW = $clog2(OVERSAMPLE);
    localparam logic [CW-1:0] CNT_LAST    = CW'(OVERSAMPLE - 1);
    localparam logic [CW-1:0] CNT_CONFIRM = CW'(OVERSAMPLE / 2 - 1);

    rx_state_e          state;
    logic [CW-1:0]      cnt;
    logic [2:0]         idx;
    logic [BYTE_W-1:0]  shreg;
    logic               par_s;
    logic               all_zero;
    logic               mid;

    assign mid = tick && (cnt == CNT_LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            cnt      <= '0;
            idx      <= '0;
            shreg    <= '0;
            par_s    <= 1'b0;
            all_zero <= 1'b0;
            ev_valid <= 1'b0;
            ev       <= '0;
        end else begin
            ev_valid <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (tick && !line) begin
                        state <= ST_START;
                        cnt   <= '0;
                    end
                end
                ST_START: begin
                    if (tick) begin
                        if (cnt == CNT_CONFIRM) begin
                            cnt      <= '0;
                            idx      <= '0;
                            shreg    <= '0;
                            par_s    <= 1'b0;
                            all_zero <= 1'b1;
                            state    <= line ? ST_IDLE : ST_DATA;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                end
                ST_DATA: begin
                    if (mid) begin
                        cnt        <= '0;
                        shreg[idx] <= line;
                        all_zero   <= all_zero & ~line;
                        if (idx == last_bit_idx(cfg.wlen))
                            state <= cfg.par_en ? ST_PAR : ST_STOP;
                        else
                            idx <= idx + 1'b1;
                    end else if (tick) begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_PAR: begin
                    if (mid) begin
                        cnt      <= '0;
                        par_s    <= line;
                        all_zero <= all_zero & ~line;
                        state    <= ST_STOP;
                    end else if (tick) begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_STOP: begin
                    if (mid) begin
                        cnt      <= '0;
                        ev_valid <= 1'b1;
                        ev.data  <= shreg & width_mask(cfg.wlen);
                        ev.perr  <= cfg.par_en &&
                                    (par_s != parity_expect(shreg & width_mask(cfg.wlen),
                                                            cfg.par_kind));
                        ev.ferr  <= ~line;
                        ev.brk   <= all_zero & ~line;
                        state    <= (all_zero && !line) ? ST_HOLD : ST_IDLE;
                    end else if (tick) begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_HOLD: begin
                    if (line)
                        state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R2: bits above the programmed word length never carry data
    assert_upper_zero_R2: assert property (@(posedge clk) disable iff (rst)
        ev_valid |-> ((ev.data & ~width_mask(cfg.wlen)) == '0));

    // R8: a break character is followed by waiting, not another character
    assert_break_single_R8: assert property (@(posedge clk) disable iff (rst)
        (ev_valid && ev.brk) |=> (!ev_valid && state == ST_HOLD));

    // R1: a frame is only entered after the confirmation sample was low
    assert_start_confirm_R1: assert property (@(posedge clk) disable iff (rst)
        (state == ST_START && tick && cnt == CNT_CONFIRM && line) |=> state == ST_IDLE);

endmodule

// File: rtl/rx_status_regs.sv
module rx_status_regs
    import serial_rx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ev_valid,
    input  rx_event_t         ev,
    input  logic              rd_data,
    input  logic              rd_shadow,
    input  logic              rd_status,
    input  logic              loop_en,
    output logic [BYTE_W-1:0] rdata,
    output logic [7:0]        status,
    output logic              avail_irq,
    output logic              err_irq
);
    logic [BYTE_W-1:0] hold_q;
    logic avail_q, ovr_q, pe_q, fe_q, brk_q;
    logic avail_n, ovr_n, pe_n, fe_n, brk_n;
    logic keep;

    assign keep = ~rd_status;

    always_comb begin
        avail_n = ev_valid ? 1'b1 : (avail_q & ~rd_data);
        ovr_n   = (ovr_q & keep) | (ev_valid & avail_q & ~rd_data);
        pe_n    = (pe_q  & keep) | (ev_valid & ev.perr);
        fe_n    = (fe_q  & keep) | (ev_valid & ev.ferr);
        brk_n   = (brk_q & keep) | (ev_valid & ev.brk);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q  <= '0;
            avail_q <= 1'b0;
            ovr_q   <= 1'b0;
            pe_q    <= 1'b0;
            fe_q    <= 1'b0;
            brk_q   <= 1'b0;
            rdata   <= '0;
        end else begin
            if (ev_valid)
                hold_q <= ev.data;
            avail_q <= avail_n;
            ovr_q   <= ovr_n;
            pe_q    <= pe_n;
            fe_q    <= fe_n;
            brk_q   <= brk_n;
            if (rd_status)
                rdata <= status;
            else if (rd_data || rd_shadow)
                rdata <= hold_q;
        end
    end

    assign status    = {3'b000, brk_q, fe_q, pe_q, ovr_q, avail_q};
    assign avail_irq = avail_q & ~loop_en;
    assign err_irq   = (ovr_q | pe_q | fe_q | brk_q) & ~loop_en;

    // R3: a consuming read with no new character empties the buffer
    assert_read_clears_R3: assert property (@(posedge clk) disable iff (rst)
        (rd_data && !ev_valid) |=> !status[0]);

    // R4: a shadow read alone leaves data-available as it was
    assert_shadow_keeps_R4: assert property (@(posedge clk) disable iff (rst)
        (rd_shadow && !rd_data && !ev_valid && status[0]) |=> status[0]);

    // R5: a character landing on a full buffer flags overrun
    assert_overrun_set_R5: assert property (@(posedge clk) disable iff (rst)
        (ev_valid && status[0] && !rd_data) |=> status[1]);

    // R9: a status read with no new character clears every error flag
    assert_status_clear_R9: assert property (@(posedge clk) disable iff (rst)
        (rd_status && !ev_valid) |=> (status[4:1] == 4'b0000));

    // R9: an error arriving with a status read survives it
    assert_new_err_wins_R9: assert property (@(posedge clk) disable iff (rst)
        (ev_valid && ev.ferr && rd_status) |=> status[3]);

endmodule

// File: rtl/serial_rx_status.sv
module serial_rx_status
    import serial_rx_pkg::*;
#(
    parameter int OVERSAMPLE  = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       baud_tick,
    input  logic       rxd,
    input  logic       loop_en,
    input  logic       loop_txd,
    input  logic [1:0] word_len,
    input  logic       parity_en,
    input  logic [1:0] parity_kind,
    input  logic       rd_data,
    input  logic       rd_shadow,
    input  logic       rd_status,
    output logic [7:0] rdata,
    output logic [7:0] status,
    output logic       avail_irq,
    output logic       err_irq
);
    logic      line;
    logic      ev_valid;
    rx_event_t ev;
    rx_cfg_t   cfg;

    assign cfg.wlen     = wlen_e'(word_len);
    assign cfg.par_en   = parity_en;
    assign cfg.par_kind = par_kind_e'(parity_kind);

    rx_line_select #(.SYNC_STAGES(SYNC_STAGES)) u_line (
        .clk      (clk),
        .rst      (rst),
        .rxd      (rxd),
        .loop_en  (loop_en),
        .loop_txd (loop_txd),
        .line     (line)
    );

    rx_frame_engine #(.OVERSAMPLE(OVERSAMPLE)) u_frame (
        .clk      (clk),
        .rst      (rst),
        .tick     (baud_tick),
        .line     (line),
        .cfg      (cfg),
        .ev_valid (ev_valid),
        .ev       (ev)
    );

    rx_status_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .ev_valid  (ev_valid),
        .ev        (ev),
        .rd_data   (rd_data),
        .rd_shadow (rd_shadow),
        .rd_status (rd_status),
        .loop_en   (loop_en),
        .rdata     (rdata),
        .status    (status),
        .avail_irq (avail_irq),
        .err_irq   (err_irq)
    );

    // R10: the request lines stay low with nothing buffered or flagged
    assert_irq_source_R10: assert property (@(posedge clk) disable iff (rst)
        (status[4:0] == 5'b0) |-> (!avail_irq && !err_irq));

endmodule

// File: tb/sim_serial_rx_status.sv
module sim_serial_rx_status;
    localparam int CLK_PERIOD = 10;
    localparam int BIT_CLKS   = 32;   // 16 ticks, one tick every 2 clocks

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic baud_tick = 1'b0;
    logic rxd = 1'b1;
    logic loop_en = 1'b0;
    logic loop_txd = 1'b1;
    logic [1:0] word_len = 2'b11;
    logic parity_en = 1'b0;
    logic [1:0] parity_kind = 2'b00;
    logic rd_data = 1'b0;
    logic rd_shadow = 1'b0;
    logic rd_status = 1'b0;
    logic [7:0] rdata;
    logic [7:0] status;
    logic avail_irq;
    logic err_irq;

    int checks = 0;
    int errors = 0;
    logic [7:0] exp_q[$];
    string      tag_q[$];

    serial_rx_status u0 (
        .clk(clk), .rst(rst), .baud_tick(baud_tick), .rxd(rxd),
        .loop_en(loop_en), .loop_txd(loop_txd), .word_len(word_len),
        .parity_en(parity_en), .parity_kind(parity_kind),
        .rd_data(rd_data), .rd_shadow(rd_shadow), .rd_status(rd_status),
        .rdata(rdata), .status(status), .avail_irq(avail_irq), .err_irq(err_irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        if (rst) baud_tick <= 1'b0;
        else     baud_tick <= ~baud_tick;
    end

    task automatic check8(input logic [7:0] act, input logic [7:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    // monitor: compares read results against the scoreboard queue
    always @(posedge clk) begin
        if ((rd_data || rd_shadow || rd_status) && exp_q.size() > 0) begin
            logic [7:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            #(CLK_PERIOD/4);
            check8(rdata, e, t);
        end
    end

    // driver: one read strobe, expected result pushed to the scoreboard
    task automatic do_read(input int kind, input logic [7:0] exp, input string tag);
        @(negedge clk);
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        rd_status = (kind == 0);
        rd_data   = (kind == 1);
        rd_shadow = (kind == 2);
        @(negedge clk);
        rd_status = 1'b0;
        rd_data   = 1'b0;
        rd_shadow = 1'b0;
    endtask

    task automatic drive_bit(input logic use_loop, input logic v, input int clks);
        if (use_loop) loop_txd = v; else rxd = v;
        repeat (clks) @(negedge clk);
    endtask

    task automatic send_frame(input logic use_loop, input logic [7:0] d, input int nbits,
                              input logic use_par, input logic pbit, input logic sbit);
        @(negedge clk);
        drive_bit(use_loop, 1'b0, BIT_CLKS);
        for (int i = 0; i < nbits; i++) drive_bit(use_loop, d[i], BIT_CLKS);
        if (use_par) drive_bit(use_loop, pbit, BIT_CLKS);
        drive_bit(use_loop, sbit, BIT_CLKS);
        drive_bit(use_loop, 1'b1, BIT_CLKS);
    endtask

    function automatic logic par_of(input logic [7:0] d, input int nbits, input logic [1:0] k);
        logic [7:0] m;
        m = d & (8'hFF >> (8 - nbits));
        case (k)
            2'b00:   return ~(^m);
            2'b01:   return ^m;
            2'b10:   return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R12 reset state
        check8(status, 8'h00, "R12 status after reset");
        check8(rdata, 8'h00, "R12 rdata after reset");
        check8({6'b0, avail_irq, err_irq}, 8'h00, "R12 irqs after reset");

        // R2/R3 8-bit clean frame
        send_frame(1'b0, 8'hA5, 8, 1'b0, 1'b0, 1'b1);
        check8({7'b0, avail_irq}, 8'h01, "R10 avail_irq raised");
        do_read(0, 8'h01, "R9 status avail only");
        do_read(1, 8'hA5, "R2 byte A5 LSB first");
        check8(status, 8'h00, "R3 avail cleared by read");
        send_frame(1'b0, 8'h3C, 8, 1'b0, 1'b0, 1'b1);
        do_read(1, 8'h3C, "R2 byte 3C");

        // R2 5-bit: upper bits zero
        word_len = 2'b00;
        send_frame(1'b0, 8'hFF, 5, 1'b0, 1'b0, 1'b1);
        do_read(1, 8'h1F, "R2 5-bit padding");
        word_len = 2'b10;
        send_frame(1'b0, 8'h55, 7, 1'b0, 1'b0, 1'b1);
        do_read(1, 8'h55, "R2 7-bit byte");

        // R6 parity: even correct, then wrong, then odd correct
        parity_en = 1'b1; parity_kind = 2'b01;
        send_frame(1'b0, 8'h13, 7, 1'b1, par_of(8'h13, 7, 2'b01), 1'b1);
        do_read(0, 8'h01, "R6 even parity good");
        do_read(1, 8'h13, "R6 even parity byte");
        send_frame(1'b0, 8'h13, 7, 1'b1, ~par_of(8'h13, 7, 2'b01), 1'b1);
        check8({7'b0, err_irq}, 8'h01, "R10 err_irq on parity");
        do_read(0, 8'h05, "R6 even parity bad");
        check8(status, 8'h01, "R9 errors cleared by status read");
        do_read(1, 8'h13, "R6 byte kept");
        parity_kind = 2'b00;
        send_frame(1'b0, 8'h2A, 7, 1'b1, par_of(8'h2A, 7, 2'b00), 1'b1);
        do_read(0, 8'h01, "R6 odd parity good");
        do_read(1, 8'h2A, "R6 odd byte");
        parity_kind = 2'b10;
        send_frame(1'b0, 8'h2A, 7, 1'b1, 1'b0, 1'b1);
        do_read(0, 8'h05, "R6 mark parity expects 1");
        do_read(1, 8'h2A, "R6 mark byte");
        parity_en = 1'b0; word_len = 2'b11;

        // R7 framing
        send_frame(1'b0, 8'h81, 8, 1'b0, 1'b0, 1'b0);
        do_read(0, 8'h09, "R7 framing flag");
        do_read(1, 8'h81, "R7 byte");

        // R8 break: line low for 14 bit times
        @(negedge clk);
        rxd = 1'b0;
        repeat (BIT_CLKS * 14) @(negedge clk);
        rxd = 1'b1;
        repeat (BIT_CLKS * 2) @(negedge clk);
        do_read(0, 8'h19, "R8 break flags");
        do_read(1, 8'h00, "R8 break byte zero");
        repeat (BIT_CLKS * 4) @(negedge clk);
        check8(status, 8'h00, "R8 single break character");

        // R5 overrun
        send_frame(1'b0, 8'h11, 8, 1'b0, 1'b0, 1'b1);
        send_frame(1'b0, 8'h22, 8, 1'b0, 1'b0, 1'b1);
        do_read(0, 8'h03, "R5 overrun flag");
        do_read(1, 8'h22, "R5 newer byte kept");

        // R4 shadow read
        send_frame(1'b0, 8'h6E, 8, 1'b0, 1'b0, 1'b1);
        do_read(2, 8'h6E, "R4 shadow byte");
        check8(status, 8'h01, "R4 avail kept after shadow");
        do_read(1, 8'h6E, "R3 consume after shadow");

        // R1 glitch: low for 3 ticks
        @(negedge clk);
        rxd = 1'b0;
        repeat (6) @(negedge clk);
        rxd = 1'b1;
        repeat (BIT_CLKS * 12) @(negedge clk);
        check8(status, 8'h00, "R1 glitch dropped");

        // R9 status read coinciding with a new framing error
        begin
            logic seen;
            seen = 1'b0;
            fork
                send_frame(1'b0, 8'h44, 8, 1'b0, 1'b0, 1'b0);
                begin
                    rd_status = 1'b1;
                    for (int c = 0; c < BIT_CLKS * 12 && !seen; c++) begin
                        @(negedge clk);
                        if (status[3]) seen = 1'b1;
                    end
                    rd_status = 1'b0;
                end
            join
            check8({7'b0, seen}, 8'h01, "R9 new error survives read");
            do_read(1, 8'h44, "R9 byte");
            do_read(0, 8'h08, "R9 flag read once more");
        end

        // R11/R10 loopback: pin held low, frame on loopback input
        @(negedge clk);
        loop_en = 1'b1;
        rxd = 1'b0;
        send_frame(1'b1, 8'h5A, 8, 1'b0, 1'b0, 1'b1);
        check8(status, 8'h01, "R11 loopback byte received");
        check8({6'b0, avail_irq, err_irq}, 8'h00, "R10 no requests in loopback");
        do_read(1, 8'h5A, "R11 loopback byte");
        send_frame(1'b1, 8'h0F, 8, 1'b0, 1'b0, 1'b0);
        check8({7'b0, err_irq}, 8'h00, "R10 err_irq quiet in loopback");
        do_read(0, 8'h09, "R11 loopback framing");
        do_read(1, 8'h0F, "R11 loopback byte 2");
        rxd = 1'b1;
        repeat (4) @(negedge clk);
        loop_en = 1'b0;
        repeat (BIT_CLKS * 12) @(negedge clk);
        check8(status, 8'h00, "R11 clean return from loopback");

        repeat (4) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule